// File: doc/BRIEF.md
# Read-Bypass Host Request Scheduler

This block sits between a pipelined host bus front end and a memory back end. The host presents memory read and write requests, each with an address and, for writes, a data word. Accepted requests wait in a small age-ordered pending queue. The scheduler sends them to memory one at a time over a simple command/acknowledge port whose latency can vary. A read may overtake older writes that are still waiting, but only when none of those writes touches the same cache line. Completions always go back to the host in the order the requests were accepted, whatever order memory served them in.

Special acknowledge cycles are dropped and get no response. These are the system-management acknowledge and the clock-stop acknowledge, which arrive coded as memory operations. An address-error input stops any further commands from going to memory; logging the error is left to another unit. A bus-initialization input clears the queue and every host-side state machine. Every response is a normal completion: the block has no deferred, failure or abort responses.

Top module: `hostq_sched`

## Requirements
- R1: A request is accepted at a clock edge when `req_valid` is 1, `req_kind` is 2'b00, `bus_init` is 0 and fewer than DEPTH (4) requests are pending. `req_stall` is 1 exactly while DEPTH requests are pending. A strobe seen while `req_stall` is 1 is not accepted and produces no response.
- R2: A strobe with `req_kind` 2'b01 (management acknowledge), 2'b10 (clock-stop acknowledge) or 2'b11 (reserved) is dropped. It causes no memory command and no response.
- R3: A pending read is sent to memory ahead of an older pending write only when its line address (`req_addr[AW-1:5]`) differs from the line of every older write that has not yet completed. A read whose line matches such a write waits until that write has completed. Address bits [4:0] take no part in the comparison.
- R4: At most one memory command is outstanding, and `mem_req_valid` is a one-cycle pulse. When memory is free, the oldest eligible read is chosen. If no read is eligible, the oldest unsent write is chosen.
- R5: Each accepted request gets exactly one response pulse on `rsp_valid`, in acceptance order. `rsp_seq` counts 0,1,2,… modulo 8 from reset or bus initialization. `rsp_write` gives the request type. `rsp_rdata` carries the `mem_rdata` of a read's acknowledge, and is 0 for a write.
- R6: Once `addr_err` is sampled at 1, no new memory command is sent until bus initialization or reset. A command already outstanding still completes and is still answered.
- R7: While `bus_init` is 1 the pending queue and the error halt are cleared and no request is accepted, including in the pulse's last cycle. The cycle after any cycle with `bus_init` at 1 shows no response and no memory command. Numbering restarts at 0.
- R8: Right after reset, `req_stall`, `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_init | input | 1 | Bus initialization: clears queue and state |
| addr_err | input | 1 | Address error: halts issue to memory |
| req_valid | input | 1 | Host request strobe |
| req_kind | input | 2 | 00 memory op, 01 management ack, 10 clock-stop ack, 11 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Write data |
| req_stall | output | 1 | Queue full, strobes not accepted |
| mem_req_valid | output | 1 | One-cycle memory command pulse |
| mem_req_write | output | 1 | Command is a write |
| mem_req_addr | output | AW | Command address |
| mem_req_wdata | output | DW | Command write data |
| mem_ack | input | 1 | Memory finished the outstanding command |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| rsp_valid | output | 1 | One-cycle host response pulse |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_seq | output | SEQ_W | Arrival number of the answered request |
| rsp_rdata | output | DW | Read data, 0 for writes |

## Verification
The bench builds two queues in which reads sit behind slow writes: one where the lines differ and one where a read shares a line with a waiting write. It then checks the exact order of memory commands. A design that ignored the hazard would return stale data for the matching read. One that never bypassed would send commands in plain arrival order. An address error is raised while a read is in flight. A design that stopped too early would lose that read's response, and one that did not stop would send the next command. A strobe is held through the whole initialization pulse and another is offered while the queue is full. Both must leave no trace in the responses or numbering.

// File: rtl/hostq_pkg.sv
package hostq_pkg;

    typedef enum logic [1:0] {
        KIND_MEM        = 2'b00,
        KIND_MGMT_ACK   = 2'b01,
        KIND_CLKSTOP_ACK = 2'b10,
        KIND_RSVD       = 2'b11
    } req_kind_e;

    function automatic logic kind_is_mem(input logic [1:0] kind);
        return kind == KIND_MEM;
    endfunction

endpackage

// File: rtl/hostq_hazard.sv
module hostq_hazard #(
    parameter int DEPTH = 4,
    parameter int LW    = 11
) (
    input  logic [DEPTH-1:0]         pend_wr,
    input  logic [DEPTH-1:0][LW-1:0] line,
    output logic [DEPTH-1:0]         blocked
);

    // Row i is blocked by any older (lower index) write still pending on the same line.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        if (gi == 0) begin : g_head
            assign blocked[gi] = 1'b0;
        end else begin : g_tail
            logic [gi-1:0] hit;
            for (genvar gj = 0; gj < gi; gj++) begin : g_col
                assign hit[gj] = pend_wr[gj] && (line[gj] == line[gi]);
            end
            assign blocked[gi] = |hit;
        end
    end

endmodule

// File: rtl/hostq_pick.sv
module hostq_pick #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] rd_ok,
    input  logic [DEPTH-1:0] wr_ok,
    output logic             gnt_vld,
    output logic [DEPTH-1:0] gnt_oh
);

    logic [DEPTH-1:0] rd_first;
    logic [DEPTH-1:0] wr_first;

    // Lowest set index is the oldest entry.
    always_comb begin
        rd_first = '0;
        wr_first = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (rd_ok[i]) rd_first = DEPTH'(1) << i;
            if (wr_ok[i]) wr_first = DEPTH'(1) << i;
        end
    end

    assign gnt_oh  = (|rd_ok) ? rd_first : wr_first;
    assign gnt_vld = |(rd_ok | wr_ok);

endmodule

// File: rtl/hostq_sched.sv
module hostq_sched
    import hostq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int DEPTH    = 4,
    parameter int LINE_LSB = 5,
    parameter int SEQ_W    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_init,
    input  logic             addr_err,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_stall,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [AW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             rsp_valid,
    output logic             rsp_write,
    output logic [SEQ_W-1:0] rsp_seq,
    output logic [DW-1:0]    rsp_rdata
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = AW - LINE_LSB;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic             iss;
        logic             dn;
        logic [SEQ_W-1:0] seq;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CW-1:0]    cnt;
        logic [SEQ_W-1:0] seq_ctr;
        logic             busy;
        logic [SEQ_W-1:0] busy_seq;
        logic             halt;
        logic             mreq_vld;
        logic             mreq_wr;
        logic [AW-1:0]    mreq_addr;
        logic [DW-1:0]    mreq_data;
        logic             rsp_vld;
        logic             rsp_wr;
        logic [SEQ_W-1:0] rsp_seq;
        logic [DW-1:0]    rsp_data;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH-1:0]         pend_wr;
    logic [DEPTH-1:0][LW-1:0] line;
    logic [DEPTH-1:0]         blocked;
    logic [DEPTH-1:0]         rd_ok;
    logic [DEPTH-1:0]         wr_ok;
    logic                     gnt_vld;
    logic [DEPTH-1:0]         gnt_oh;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_flags
        assign pend_wr[gi] = st_q.ent[gi].vld && st_q.ent[gi].wr && !st_q.ent[gi].dn;
        assign line[gi]    = st_q.ent[gi].addr[AW-1:LINE_LSB];
        assign rd_ok[gi]   = st_q.ent[gi].vld && !st_q.ent[gi].wr && !st_q.ent[gi].iss
                             && !blocked[gi];
        assign wr_ok[gi]   = st_q.ent[gi].vld && st_q.ent[gi].wr && !st_q.ent[gi].iss;
    end

    hostq_hazard #(.DEPTH(DEPTH), .LW(LW)) u_hazard (
        .pend_wr (pend_wr),
        .line    (line),
        .blocked (blocked)
    );

    hostq_pick #(.DEPTH(DEPTH)) u_pick (
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok),
        .gnt_vld (gnt_vld),
        .gnt_oh  (gnt_oh)
    );

    ent_t [DEPTH-1:0] work;
    logic [CW-1:0]    cnt_w;
    logic             retire;
    logic             accept;
    logic             issue;

    always_comb begin
        st_d          = st_q;
        st_d.mreq_vld = 1'b0;
        st_d.rsp_vld  = 1'b0;
        work          = st_q.ent;
        cnt_w         = st_q.cnt;
        retire        = st_q.ent[0].vld && st_q.ent[0].dn;
        accept        = req_valid && kind_is_mem(req_kind) && (st_q.cnt != CW'(DEPTH));
        issue         = !st_q.busy && !st_q.halt && !addr_err && gnt_vld;

        if (bus_init) begin
            st_d = '0;
        end else begin
            // completion from memory, matched by arrival number
            if (st_q.busy && mem_ack) begin
                st_d.busy = 1'b0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (work[i].vld && work[i].iss && !work[i].dn
                        && work[i].seq == st_q.busy_seq) begin
                        work[i].dn = 1'b1;
                        if (!work[i].wr) work[i].data = mem_rdata;
                    end
                end
            end

            if (addr_err) st_d.halt = 1'b1;

            // send one command to memory
            if (issue) begin
                st_d.busy = 1'b1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (gnt_oh[i]) begin
                        work[i].iss    = 1'b1;
                        st_d.busy_seq  = st_q.ent[i].seq;
                        st_d.mreq_vld  = 1'b1;
                        st_d.mreq_wr   = st_q.ent[i].wr;
                        st_d.mreq_addr = st_q.ent[i].addr;
                        st_d.mreq_data = st_q.ent[i].data;
                    end
                end
            end

            // answer the head entry in arrival order
            if (retire) begin
                st_d.rsp_vld  = 1'b1;
                st_d.rsp_wr   = st_q.ent[0].wr;
                st_d.rsp_seq  = st_q.ent[0].seq;
                st_d.rsp_data = st_q.ent[0].wr ? '0 : st_q.ent[0].data;
                for (int i = 0; i < DEPTH - 1; i++) begin
                    work[i] = work[i+1];
                end
                work[DEPTH-1] = '0;
                cnt_w         = cnt_w - CW'(1);
            end

            // append behind the youngest entry
            if (accept) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == cnt_w) begin
                        work[i].vld  = 1'b1;
                        work[i].wr   = req_write;
                        work[i].iss  = 1'b0;
                        work[i].dn   = 1'b0;
                        work[i].seq  = st_q.seq_ctr;
                        work[i].addr = req_addr;
                        work[i].data = req_wdata;
                    end
                end
                cnt_w        = cnt_w + CW'(1);
                st_d.seq_ctr = st_q.seq_ctr + SEQ_W'(1);
            end

            st_d.ent = work;
            st_d.cnt = cnt_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_stall     = (st_q.cnt == CW'(DEPTH));
    assign mem_req_valid = st_q.mreq_vld;
    assign mem_req_write = st_q.mreq_wr;
    assign mem_req_addr  = st_q.mreq_addr;
    assign mem_req_wdata = st_q.mreq_data;
    assign rsp_valid     = st_q.rsp_vld;
    assign rsp_write     = st_q.rsp_wr;
    assign rsp_seq       = st_q.rsp_seq;
    assign rsp_rdata     = st_q.rsp_data;

    // response numbering tracker for the ordering check
    logic             seen_q;
    logic [SEQ_W-1:0] last_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (bus_init) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (rsp_valid) begin
            seen_q <= 1'b1;
            last_q <= rsp_seq;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R1
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall |=> st_q.cnt <= $past(st_q.cnt)); // R1
    AST_SPECIAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !kind_is_mem(req_kind)) |=> st_q.cnt <= $past(st_q.cnt)); // R2
    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R4
    AST_RSP_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && seen_q) |-> rsp_seq == last_q + SEQ_W'(1)); // R5
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt && !bus_init) |=> !mem_req_valid); // R6
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> (st_q.cnt == '0 && !rsp_valid && !mem_req_valid)); // R7

endmodule

// File: tb/hostq_sched_bench.sv
module hostq_sched_bench;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_init = 1'b0;
    logic          addr_err = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_stall;
    logic          mem_req_valid;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          rsp_valid;
    logic          rsp_write;
    logic [2:0]    rsp_seq;
    logic [DW-1:0] rsp_rdata;

    hostq_sched u_hostq_sched (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .addr_err(addr_err),
        .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_stall(req_stall),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_seq(rsp_seq),
        .rsp_rdata(rsp_rdata)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // {kind[1:0], write, line[3:0], data/offset[7:0]}
    localparam logic [14:0] VEC [0:11] = '{
        {2'd0, 1'b1, 4'd1, 8'h11},
        {2'd0, 1'b0, 4'd1, 8'h03},
        {2'd1, 1'b0, 4'd1, 8'h00},
        {2'd0, 1'b1, 4'd2, 8'h22},
        {2'd0, 1'b0, 4'd2, 8'h1f},
        {2'd0, 1'b0, 4'd3, 8'h04},
        {2'd0, 1'b1, 4'd1, 8'h33},
        {2'd2, 1'b1, 4'd1, 8'h77},
        {2'd0, 1'b0, 4'd1, 8'h08},
        {2'd3, 1'b0, 4'd3, 8'h00},
        {2'd0, 1'b1, 4'd3, 8'h44},
        {2'd0, 1'b0, 4'd3, 8'h10}
    };

    // memory model and golden arrival-order image
    logic [DW-1:0] mem_model [0:15];
    logic [DW-1:0] gold [0:15];
    int lat = 3;
    int issue_n = 0;
    logic [3:0] log_line [0:63];
    logic       log_wr   [0:63];

    // expected responses
    int          exp_n = 0;
    int          rsp_got = 0;
    int          seq_ctr = 0;
    logic [2:0]  exp_seq  [0:63];
    logic        exp_wr   [0:63];
    logic [DW-1:0] exp_data [0:63];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = 32'hA000_0000 + i;
            gold[i]      = 32'hA000_0000 + i;
        end
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                log_line[issue_n % 64] = mem_req_addr[8:5];
                log_wr[issue_n % 64]   = mem_req_write;
                issue_n++;
                repeat (lat) @(negedge clk);
                if (mem_req_write) begin
                    mem_model[mem_req_addr[8:5]] = mem_req_wdata;
                    mem_rdata = '0;
                end else begin
                    mem_rdata = mem_model[mem_req_addr[8:5]];
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // response monitor (R5)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (rsp_got >= exp_n) begin
                check(1'b0, "R5", "unexpected response seq", DW'(rsp_seq), '0);
            end else begin
                check(rsp_seq == exp_seq[rsp_got % 64], "R5", "rsp_seq",
                      DW'(rsp_seq), DW'(exp_seq[rsp_got % 64]));
                check(rsp_write == exp_wr[rsp_got % 64], "R5", "rsp_write",
                      DW'(rsp_write), DW'(exp_wr[rsp_got % 64]));
                check(rsp_rdata == exp_data[rsp_got % 64], "R5/R3", "rsp_rdata",
                      rsp_rdata, exp_data[rsp_got % 64]);
            end
            rsp_got++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // one strobe per cycle; called at a negedge, returns at the next negedge
    task automatic send(input logic [1:0] kind, input logic wr, input logic [3:0] ln,
                        input logic [7:0] d);
        while (req_stall) @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_write = wr;
        req_addr  = {7'b0, ln, d[4:0]};
        req_wdata = {24'h5A5A5A, d};
        if (kind == 2'd0) begin
            exp_seq[exp_n % 64] = 3'(seq_ctr);
            exp_wr[exp_n % 64]  = wr;
            if (wr) begin
                gold[ln] = {24'h5A5A5A, d};
                exp_data[exp_n % 64] = '0;
            end else begin
                exp_data[exp_n % 64] = gold[ln];
            end
            exp_n++;
            seq_ctr++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (rsp_got < exp_n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        check(rsp_got == exp_n, req, "response count", DW'(rsp_got), DW'(exp_n));
    endtask

    task automatic check_order(input int base, input logic [3:0] l0, input logic w0,
                               input logic [3:0] l1, input logic w1,
                               input logic [3:0] l2, input logic w2,
                               input logic [3:0] l3, input logic w3, input string req);
        logic [3:0] el [4];
        logic       ew [4];
        el = '{l0, l1, l2, l3};
        ew = '{w0, w1, w2, w3};
        for (int k = 0; k < 4; k++) begin
            check(log_line[(base + k) % 64] == el[k] && log_wr[(base + k) % 64] == ew[k],
                  req, "issue order {wr,line}",
                  DW'({log_wr[(base + k) % 64], log_line[(base + k) % 64]}),
                  DW'({ew[k], el[k]}));
        end
    endtask

    initial begin
        int base;
        int normals;

        // reset state (R8)
        repeat (2) @(negedge clk);
        check(!req_stall && !mem_req_valid && !rsp_valid, "R8", "outputs in reset",
              DW'({req_stall, mem_req_valid, rsp_valid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_stall && !mem_req_valid && !rsp_valid, "R8", "outputs after reset",
              DW'({req_stall, mem_req_valid, rsp_valid}), '0);

        // vector walk: mixed traffic and special cycles (R2, R3, R5)
        base = issue_n;
        normals = 0;
        lat = 3;
        for (int v = 0; v < 12; v++) begin
            send(VEC[v][14:13], VEC[v][12], VEC[v][11:8], VEC[v][7:0]);
            if (VEC[v][14:13] == 2'd0) normals++;
        end
        drain("R5");
        check(issue_n - base == normals, "R2", "memory commands for walk",
              DW'(issue_n - base), DW'(normals));

        // full queue (R1)
        lat = 30;
        send(2'd0, 1'b0, 4'd4, 8'h00);
        send(2'd0, 1'b1, 4'd5, 8'h55);
        send(2'd0, 1'b0, 4'd6, 8'h00);
        send(2'd0, 1'b1, 4'd7, 8'h66);
        check(req_stall, "R1", "req_stall with 4 pending", DW'(req_stall), 1);
        req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b1;
        req_addr = 16'h0100; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 2;
        drain("R1");
        check(!req_stall, "R1", "req_stall after drain", DW'(req_stall), 0);

        // bypass with distinct lines (R3, R4)
        lat = 6;
        base = issue_n;
        send(2'd0, 1'b1, 4'd1, 8'h81);
        send(2'd0, 1'b1, 4'd2, 8'h82);
        send(2'd0, 1'b0, 4'd3, 8'h00);
        send(2'd0, 1'b0, 4'd1, 8'h1c);
        drain("R4");
        check_order(base, 4'd1, 1'b1, 4'd3, 1'b0, 4'd1, 1'b0, 4'd2, 1'b1, "R4");

        // read matching a waiting write stays behind it (R3)
        base = issue_n;
        send(2'd0, 1'b1, 4'd5, 8'h95);
        send(2'd0, 1'b1, 4'd6, 8'h96);
        send(2'd0, 1'b0, 4'd6, 8'h07);
        send(2'd0, 1'b0, 4'd7, 8'h00);
        drain("R3");
        check_order(base, 4'd5, 1'b1, 4'd7, 1'b0, 4'd6, 1'b1, 4'd6, 1'b0, "R3");

        // address error halts issue, in-flight read still answered (R6)
        lat = 8;
        base = issue_n;
        send(2'd0, 1'b0, 4'd2, 8'h00);
        @(negedge clk);
        addr_err = 1'b1;
        @(negedge clk);
        addr_err = 1'b0;
        send(2'd0, 1'b0, 4'd3, 8'h00);
        repeat (40) @(negedge clk);
        check(issue_n - base == 1, "R6", "commands after addr_err",
              DW'(issue_n - base), 1);
        check(rsp_got == exp_n - 1, "R6", "in-flight read answered",
              DW'(rsp_got), DW'(exp_n - 1));

        // bus initialization with a strobe held through its last cycle (R7)
        req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b0;
        req_addr = 16'h0080; req_wdata = '0;
        bus_init = 1'b1;
        repeat (3) @(negedge clk);
        bus_init = 1'b0;
        req_valid = 1'b0;
        exp_n = 0; rsp_got = 0; seq_ctr = 0;
        base = issue_n;
        repeat (10) @(negedge clk);
        check(rsp_got == 0, "R7", "responses after init", DW'(rsp_got), 0);
        check(issue_n == base, "R7", "commands after init", DW'(issue_n - base), 0);
        check(!req_stall, "R7", "queue empty after init", DW'(req_stall), 0);
        lat = 2;
        send(2'd0, 1'b0, 4'd4, 8'h00);
        drain("R7");
        check(issue_n - base == 1, "R7", "halt cleared by init", DW'(issue_n - base), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule